// File: doc/BRIEF.md
# Pipelined 5x5 Gaussian Window Filter

This block smooths an image one neighbourhood at a time. Each clock cycle it can take a complete 5x5 window of 8-bit pixels, already assembled by upstream logic, together with a valid strobe. It returns one smoothed pixel with a matching strobe. The arithmetic runs as a fixed seven-register pipeline. First, every pixel is weighted in parallel by a binomial Gaussian mask. Next, five levels of registered two-input adders reduce the weighted terms to one sum. Last, a rounding shift brings the sum back to pixel range.

Up to seven windows are in flight at any time, and windows may arrive back-to-back or with gaps. Line buffering, window assembly and border treatment belong to the surrounding logic.

Top module: `conv5_window_filter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 7 clock cycles. Every accepted window yields exactly one result and no result appears without one.
- R2: A window can be accepted on every cycle. Consecutive windows produce results on consecutive cycles, in the order they were accepted.
- R3: The pixel at row r, column c (r, c in 0..4) is read from `in_win[(5*r+c)*8 +: 8]`. It is weighted by b[r]*b[c], where b = 1, 4, 6, 4, 1.
- R4: The output equals (weighted sum + 128) >> 8, so a fraction of exactly one half rounds up. A weighted sum of zero gives 0.
- R5: A window in which all 25 pixels hold the same value p yields p.
- R6: The weighted sum never exceeds 255*256 = 65280, and no intermediate sum wraps. An all-255 window yields 255.
- R7: A synchronous active-high `rst` clears every pending valid bit, so `out_valid` is 0 in the cycle after a reset edge. Windows in flight when reset is taken produce no result.
- R8: Pixel data presented while `in_valid` is low produces no result. Such bubbles do not disturb results for valid windows on either side of them.
- R9: A window that is zero except for the centre pixel v yields (36*v + 128) >> 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all pipeline registers |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_win` as a window to be filtered |
| in_win | input | 200 | 25 packed 8-bit pixels, row-major, row 0 column 0 in the low byte |
| out_valid | output | 1 | Marks `out_pix` as a filtered result |
| out_pix | output | 8 | Filtered, rounded pixel |

## Verification
The bench sends a single non-zero pixel through each of the 25 tap positions in turn. A design with a transposed or shifted mask, or a mis-ordered adder tree, returns the wrong weight for some of these positions. Windows whose weighted sum ends in exactly one half separate round-half-up from truncation. Uniform windows at 255 catch an adder level that is one bit too narrow, because such a level wraps the sum to a small value. Back-to-back traffic, bubbles and a reset taken while windows are in flight catch a valid pipeline of the wrong depth, and also one that keeps stale results after reset.

// File: rtl/conv5_pkg.sv
package conv5_pkg;

  // Binomial coefficient C(n, k)
  function automatic int binom(input int n, input int k);
    int c;
    c = 1;
    for (int i = 0; i < k; i++) c = c * (n - i) / (i + 1);
    return c;
  endfunction

  // Weight of tap idx in a kdim x kdim binomial mask (row-major index)
  function automatic int tap_weight(input int kdim, input int idx);
    return binom(kdim - 1, idx / kdim) * binom(kdim - 1, idx % kdim);
  endfunction

  // Largest weight of the mask (centre tap)
  function automatic int peak_weight(input int kdim);
    int m;
    m = binom(kdim - 1, (kdim - 1) / 2);
    return m * m;
  endfunction

  // Operand count remaining after lvl levels of pairwise reduction
  function automatic int level_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 1) / 2;
    return c;
  endfunction

endpackage

// File: rtl/conv5_mul_stage.sv
module conv5_mul_stage
  import conv5_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int KDIM   = 5,
  parameter int WGT_W  = 6,
  parameter int PROD_W = 14
) (
  input  logic                         clk,
  input  logic [KDIM*KDIM*PIX_W-1:0]   win,
  output logic [KDIM*KDIM*PROD_W-1:0]  prod
);
  localparam int TAPS = KDIM * KDIM;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam logic [WGT_W-1:0] WT = WGT_W'(tap_weight(KDIM, t));
    logic [PROD_W-1:0] p_q;
    always_ff @(posedge clk) begin
      p_q <= PROD_W'(win[t*PIX_W +: PIX_W]) * PROD_W'(WT);
    end
    assign prod[t*PROD_W +: PROD_W] = p_q;
  end
endmodule

// File: rtl/conv5_add_level.sv
module conv5_add_level #(
  parameter int N_IN = 25,
  parameter int W_IN = 14
) (
  input  logic                                clk,
  input  logic [N_IN*W_IN-1:0]                din,
  output logic [((N_IN+1)/2)*(W_IN+1)-1:0]    dout
);
  localparam int N_OUT = (N_IN + 1) / 2;
  localparam int W_OUT = W_IN + 1;

  for (genvar k = 0; k < N_OUT; k++) begin : g_node
    logic [W_OUT-1:0] s_q;
    if (2 * k + 1 < N_IN) begin : g_pair
      always_ff @(posedge clk) begin
        s_q <= W_OUT'(din[(2*k)*W_IN +: W_IN]) + W_OUT'(din[(2*k+1)*W_IN +: W_IN]);
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        s_q <= W_OUT'(din[(2*k)*W_IN +: W_IN]);
      end
    end
    assign dout[k*W_OUT +: W_OUT] = s_q;
  end
endmodule

// File: rtl/conv5_scale.sv
module conv5_scale #(
  parameter int PIX_W   = 8,
  parameter int SUM_W   = 19,
  parameter int NORM_SH = 8
) (
  input  logic             clk,
  input  logic [SUM_W-1:0] sum,
  output logic [PIX_W-1:0] pix
);
  // Round half up, then drop the fractional bits
  function automatic logic [PIX_W-1:0] norm_round(input logic [SUM_W-1:0] s);
    logic [SUM_W:0] biased;
    biased = {1'b0, s} + (SUM_W+1)'(1 << (NORM_SH - 1));
    return biased[NORM_SH +: PIX_W];
  endfunction

  always_ff @(posedge clk) begin
    pix <= norm_round(sum);
  end
endmodule

// File: rtl/conv5_window_filter.sv
module conv5_window_filter
  import conv5_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int KDIM  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [KDIM*KDIM*PIX_W-1:0] in_win,
  output logic                       out_valid,
  output logic [PIX_W-1:0]           out_pix
);
  localparam int TAPS    = KDIM * KDIM;
  localparam int WGT_W   = $clog2(peak_weight(KDIM) + 1);
  localparam int PROD_W  = PIX_W + WGT_W;
  localparam int LEVELS  = $clog2(TAPS);
  localparam int SUM_W   = PROD_W + LEVELS;
  localparam int NORM_SH = 2 * (KDIM - 1);
  localparam int LAT     = LEVELS + 2;

  // Stage 1: weighting
  logic [TAPS*PROD_W-1:0] prod_flat;

  conv5_mul_stage #(
    .PIX_W (PIX_W),
    .KDIM  (KDIM),
    .WGT_W (WGT_W),
    .PROD_W(PROD_W)
  ) u_mul (
    .clk (clk),
    .win (in_win),
    .prod(prod_flat)
  );

  // Stages 2..LEVELS+1: registered two-input adder tree
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NI = level_count(TAPS, l);
    localparam int NO = level_count(TAPS, l + 1);
    localparam int WI = PROD_W + l;
    localparam int WO = WI + 1;
    logic [NI*WI-1:0] din;
    logic [NO*WO-1:0] dout;
    if (l == 0) begin : g_first
      assign din = prod_flat;
    end else begin : g_next
      assign din = g_lvl[l-1].dout;
    end
    conv5_add_level #(
      .N_IN(NI),
      .W_IN(WI)
    ) u_add (
      .clk (clk),
      .din (din),
      .dout(dout)
    );
  end

  // Named internal events for the checker
  logic [SUM_W-1:0] tree_sum;
  logic             tree_valid;
  assign tree_sum = g_lvl[LEVELS-1].dout;

  // Final stage: rounding shift
  conv5_scale #(
    .PIX_W  (PIX_W),
    .SUM_W  (SUM_W),
    .NORM_SH(NORM_SH)
  ) u_scale (
    .clk(clk),
    .sum(tree_sum),
    .pix(out_pix)
  );

  // Valid strobe travels alongside the data
  logic [LAT-1:0] vld_q;
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  assign tree_valid = vld_q[LAT-2];
  assign out_valid  = vld_q[LAT-1];
endmodule

// File: rtl/conv5_window_filter_chk.sv
module conv5_window_filter_chk #(
  parameter int PIX_W   = 8,
  parameter int SUM_W   = 19,
  parameter int NORM_SH = 8,
  parameter int LAT     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix,
  input logic [SUM_W-1:0] tree_sum,
  input logic             tree_valid
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(((1 << PIX_W) - 1) << NORM_SH);

  logic [CW-1:0] since_rst;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                       since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + CW'(1);
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tree_valid |-> (tree_sum <= MAX_SUM)); // R6

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    (tree_valid && tree_sum == MAX_SUM) |=> (out_valid && out_pix == '1)); // R6

  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
    (tree_valid && tree_sum == '0) |=> (out_valid && out_pix == '0)); // R4

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEAR: assert (!out_valid); // R7
    end
  end
endmodule

bind conv5_window_filter conv5_window_filter_chk #(
  .PIX_W  (PIX_W),
  .SUM_W  (SUM_W),
  .NORM_SH(NORM_SH),
  .LAT    (LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_pix   (out_pix),
  .tree_sum  (tree_sum),
  .tree_valid(tree_valid)
);

// File: tb/conv5_window_filter_tb_top.sv
module conv5_window_filter_tb_top;
  localparam int K   = 5;
  localparam int T   = K * K;
  localparam int PW  = 8;
  localparam int LAT = 7;

  typedef logic [PW-1:0] win_t [T];
  typedef struct {
    int     pix;
    longint due;
    string  tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [T*PW-1:0] in_win;
  logic            out_valid;
  logic [PW-1:0]   out_pix;

  always #2 clk = ~clk; // 250 MHz

  conv5_window_filter dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_win   (in_win),
    .out_valid(out_valid),
    .out_pix  (out_pix)
  );

  exp_t   sb[$];
  longint ecnt  = 0;
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  int     brow[K] = '{1, 4, 6, 4, 1};

  always @(posedge clk) ecnt <= ecnt + 1;

  // Separable model: weight along columns, then along rows
  function automatic int model(input win_t w);
    int acc;
    acc = 0;
    for (int r = 0; r < K; r++) begin
      int rs;
      rs = 0;
      for (int c = 0; c < K; c++) rs += brow[c] * int'(w[r*K + c]);
      acc += brow[r] * rs;
    end
    return (acc + 128) / 256;
  endfunction

  function automatic logic [T*PW-1:0] pack(input win_t w);
    logic [T*PW-1:0] v;
    for (int i = 0; i < T; i++) v[i*PW +: PW] = w[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, ecnt);
    end
  endtask

  task automatic drive(input win_t w, input bit v, input string tag);
    @(negedge clk);
    in_valid = v;
    in_win   = pack(w);
    if (v) sb.push_back('{model(w), ecnt + LAT, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic win_t fill(input int p);
    win_t w;
    for (int i = 0; i < T; i++) w[i] = PW'(p);
    return w;
  endfunction

  function automatic win_t rnd_win();
    win_t w;
    for (int i = 0; i < T; i++) w[i] = PW'($urandom);
    return w;
  endfunction

  // Monitor: compares every cycle against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      begin
        bit exp_v;
        exp_v = (sb.size() > 0) && (sb[0].due == ecnt);
        check("R1 out_valid timing", {15'd0, out_valid}, {15'd0, exp_v});
        if (exp_v) begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, {8'd0, out_pix}, 16'(e.pix));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    win_t w;
    rst      = 1'b1;
    in_valid = 1'b0;
    in_win   = '0;
    repeat (3) @(negedge clk);
    check("R7 reset state", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
    idle(2);

    // R9: centre impulse
    w = fill(0); w[12] = 8'd255; drive(w, 1'b1, "R9 centre 255");
    w = fill(0); w[12] = 8'd100; drive(w, 1'b1, "R9 centre 100");
    idle(3);

    // R3: each tap alone, back-to-back
    for (int t = 0; t < T; t++) begin
      w = fill(0); w[t] = 8'd200;
      drive(w, 1'b1, "R3 tap position");
    end
    idle(2);

    // R5 / R6: uniform windows
    drive(fill(0),   1'b1, "R5 uniform 0");
    drive(fill(1),   1'b1, "R5 uniform 1");
    drive(fill(128), 1'b1, "R5 uniform 128");
    drive(fill(200), 1'b1, "R5 uniform 200");
    drive(fill(255), 1'b1, "R6 uniform 255");
    drive(fill(255), 1'b1, "R6 uniform 255 repeat");
    idle(2);

    // R4: rounding at exactly one half and just below
    w = fill(0); w[0] = 8'd128; drive(w, 1'b1, "R4 half rounds up");
    w = fill(0); w[0] = 8'd127; drive(w, 1'b1, "R4 below half");
    w = fill(0); w[1] = 8'd32;  drive(w, 1'b1, "R4 sum 128 on weight 4");
    w = fill(0); w[0] = 8'd255; w[24] = 8'd129; drive(w, 1'b1, "R4 two corners");
    idle(2);

    // R8: bubbles carrying non-zero data
    for (int i = 0; i < 12; i++) begin
      drive(rnd_win(), 1'b1, "R8 valid between bubbles");
      drive(fill(255), 1'b0, "R8 bubble");
    end
    idle(LAT + 1);
    check("R8 no result for bubbles", 16'(sb.size()), 16'd0);

    // R2: streaming random windows every cycle
    for (int i = 0; i < 60; i++) drive(rnd_win(), 1'b1, "R2 streaming");
    idle(LAT + 2);

    // R7: reset with windows in flight
    for (int i = 0; i < 4; i++) drive(fill(90), 1'b1, "R7 pre-reset");
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    sb.delete();
    @(negedge clk);
    check("R7 valid cleared after reset", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
    idle(LAT + 2);
    drive(fill(77), 1'b1, "R7 after reset");
    idle(LAT + 3);

    check("R1 every window answered", 16'(sb.size()), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule